// File: doc/BRIEF.md
# Blinking Sign Phase Sequencer

This block sequences a five-lamp blinking road sign. The lamps are wired in three groups. Group X is lamps 1 and 2, group Y is lamps 3 and 4, and group Z is lamp 5. While the enable switch is on, the sign steps through four display phases in a loop. The first phase is dark. The second lights X. The third lights X and Y. The fourth lights X, Y and Z. After the fourth phase the sign returns to dark and repeats the cycle. When the switch is turned off, the sign goes dark at the next clock edge and stays dark.

The phase is held in a two-bit state register. The encodings are 00 = dark, 01 = X, 10 = X+Y and 11 = X+Y+Z. An external tick enable sets the pace: a phase advances only on an edge where the tick is high and the switch is on. With `TICK_GATED` set to 0, the tick is ignored and the phase advances on every edge while the switch is on.

The lamp outputs are registered. They are decoded from the next phase, so they change on the same edge as the state register.

Top module: `blink_sign_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the phase becomes 00 (dark) and all three lamp outputs are 0 after that edge, whatever `sw_on` and `tick` are.
- R2: With `sw_on` = 1 and `tick` = 1 at an edge, the phase advances 00 → 01 → 10 → 11 → 00 (wrapping).
- R3: With `sw_on` = 1 and `tick` = 0 at an edge (and `TICK_GATED` = 1), the phase and all lamp outputs keep their values.
- R4: With `sw_on` = 0 at an edge, the phase becomes 00 and all lamps are 0 after that edge, regardless of `tick` or the current phase.
- R5: `lamp_x` is 1 exactly in phases 01, 10 and 11.
- R6: `lamp_y` is 1 exactly in phases 10 and 11.
- R7: `lamp_z` is 1 only in phase 11.
- R8: The lamps build up cumulatively: `lamp_z` = 1 implies `lamp_y` = 1, and `lamp_y` = 1 implies `lamp_x` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset to the dark phase |
| sw_on | input | 1 | Enable switch; 0 forces the dark phase |
| tick | input | 1 | Advance enable for one phase step |
| lamp_x | output | 1 | Registered drive for lamps 1 and 2 |
| lamp_y | output | 1 | Registered drive for lamps 3 and 4 |
| lamp_z | output | 1 | Registered drive for lamp 5 |

## Verification
Every result appears one clock edge after the inputs that cause it. Reset, switch-off, hold and advance all update the state register and the lamp registers on that same edge, so the lamps are due exactly one cycle after the stimulus. The bench applies inputs at the falling edge and advances its own phase model at the rising edge. It then compares all three lamps at the following falling edge, which is one full edge after the stimulus and away from the edge where they change. Random switch, tick and reset patterns are mixed with directed runs: a full wrap, a long hold, switch-off from each phase, and reset while running.

// File: rtl/blink_pkg.sv
package blink_pkg;
  localparam int PHASE_W = 2;

  typedef enum logic [PHASE_W-1:0] {
    PH_DARK = 2'b00,
    PH_X    = 2'b01,
    PH_XY   = 2'b10,
    PH_XYZ  = 2'b11
  } phase_t;

  typedef struct packed {
    logic x;
    logic y;
    logic z;
  } lamps_t;
endpackage

// File: rtl/blink_next.sv
module blink_next
  import blink_pkg::*;
#(
  parameter bit TICK_GATED = 1'b1
) (
  input  phase_t cur,
  input  logic   sw_on,
  input  logic   tick,
  output phase_t nxt
);
  localparam logic FREE_RUN = (TICK_GATED == 1'b0);

  logic                 adv;
  logic [PHASE_W-1:0]   inc;

  assign adv = tick | FREE_RUN;
  assign inc = cur + 1'b1;

  always_comb begin
    if (!sw_on)   nxt = PH_DARK;
    else if (adv) nxt = phase_t'(inc);
    else          nxt = cur;
  end
endmodule

// File: rtl/blink_decode.sv
module blink_decode
  import blink_pkg::*;
(
  input  phase_t ph,
  output lamps_t lamps
);
  always_comb begin
    lamps.x = |ph;
    lamps.y = ph[PHASE_W-1];
    lamps.z = &ph;
  end
endmodule

// File: rtl/blink_sign_seq.sv
module blink_sign_seq
  import blink_pkg::*;
#(
  parameter bit TICK_GATED = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_on,
  input  logic tick,
  output logic lamp_x,
  output logic lamp_y,
  output logic lamp_z
);
  phase_t state_q;
  phase_t state_d;
  lamps_t lamps_d;
  lamps_t lamps_q;

  blink_next #(.TICK_GATED(TICK_GATED)) u_next (
    .cur   (state_q),
    .sw_on (sw_on),
    .tick  (tick),
    .nxt   (state_d)
  );

  blink_decode u_dec (
    .ph    (state_d),
    .lamps (lamps_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PH_DARK;
      lamps_q <= '0;
    end else begin
      state_q <= state_d;
      lamps_q <= lamps_d;
    end
  end

  assign lamp_x = lamps_q.x;
  assign lamp_y = lamps_q.y;
  assign lamp_z = lamps_q.z;
endmodule

// File: rtl/blink_sign_seq_chk.sv
module blink_sign_seq_chk #(
  parameter bit TICK_GATED = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic sw_on,
  input logic tick,
  input logic lamp_x,
  input logic lamp_y,
  input logic lamp_z
);
  logic go;
  assign go = sw_on && (tick || !TICK_GATED);

  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> (!lamp_x && !lamp_y && !lamp_z));

  a_r4_switch_off_dark: assert property (@(posedge clk) disable iff (rst)
    !sw_on |=> (!lamp_x && !lamp_y && !lamp_z));

  a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (rst)
    (sw_on && !tick && TICK_GATED) |=>
      ($stable(lamp_x) && $stable(lamp_y) && $stable(lamp_z)));

  a_r2_dark_to_x: assert property (@(posedge clk) disable iff (rst)
    (go && !lamp_x) |=> (lamp_x && !lamp_y && !lamp_z));

  a_r2_x_to_xy: assert property (@(posedge clk) disable iff (rst)
    (go && lamp_x && !lamp_y) |=> (lamp_x && lamp_y && !lamp_z));

  a_r2_xy_to_xyz: assert property (@(posedge clk) disable iff (rst)
    (go && lamp_y && !lamp_z) |=> (lamp_x && lamp_y && lamp_z));

  a_r2_wrap_dark: assert property (@(posedge clk) disable iff (rst)
    (go && lamp_z) |=> (!lamp_x && !lamp_y && !lamp_z));

  a_r8_cumulative: assert property (@(posedge clk) disable iff (rst)
    ((lamp_z -> lamp_y) && (lamp_y -> lamp_x)));
endmodule

bind blink_sign_seq blink_sign_seq_chk #(.TICK_GATED(TICK_GATED)) u_chk (.*);

// File: tb/test_blink_sign_seq.sv
module test_blink_sign_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_on = 1'b0;
  logic tick = 1'b0;
  logic lamp_x, lamp_y, lamp_z;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  logic [1:0] exp_ph = 2'b00;

  always #4 clk = ~clk;

  blink_sign_seq i_blink_sign_seq (
    .clk(clk), .rst(rst), .sw_on(sw_on), .tick(tick),
    .lamp_x(lamp_x), .lamp_y(lamp_y), .lamp_z(lamp_z)
  );

  function automatic logic [1:0] model_next(logic [1:0] ph, logic r, logic sw, logic tk);
    if (r)        return 2'b00;
    else if (!sw) return 2'b00;
    else if (tk)  return ph + 2'd1;
    else          return ph;
  endfunction

  function automatic logic [2:0] model_lamps(logic [1:0] ph);
    return {ph != 2'b00, ph[1], ph == 2'b11};
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(logic r, logic sw, logic tk);
    string cause;
    logic [2:0] e;
    rst = r; sw_on = sw; tick = tk;
    @(posedge clk);
    exp_ph = model_next(exp_ph, r, sw, tk);
    @(negedge clk);
    if (r)        cause = "R1";
    else if (!sw) cause = "R4";
    else if (!tk) cause = "R3";
    else          cause = "R2";
    e = model_lamps(exp_ph);
    check_bit({cause, " lamp_x R5"}, lamp_x, e[2]);
    check_bit({cause, " lamp_y R6"}, lamp_y, e[1]);
    check_bit({cause, " lamp_z R7"}, lamp_z, e[0]);
    check_bit("R8 cumulative", (!lamp_z || lamp_y) && (!lamp_y || lamp_x), 1'b1);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd1234);
    @(negedge clk);
    // R1: reset with switch on and tick high still gives dark
    step(1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0);
    // R2: full wrap twice
    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1);
    // R3: hold in each phase
    for (int p = 0; p < 4; p++) begin
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);
    end
    // R4: switch off from each phase, with tick both ways
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < p; k++) step(1'b0, 1'b1, 1'b1);
      step(1'b0, 1'b0, p[0]);
      step(1'b0, 1'b0, 1'b1);
    end
    // R1: reset from the full phase while running
    for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1);
    step(1'b1, 1'b1, 1'b1);
    // random mix
    for (int i = 0; i < 2000; i++) begin
      logic r, sw, tk;
      r  = ($urandom % 40) == 0;
      sw = ($urandom % 8) != 0;
      tk = $urandom % 2;
      step(r, sw, tk);
    end
    summary();
  end
endmodule